// File: doc/BRIEF.md
# Two-level hierarchical carry-lookahead adder

A combinational 16-bit binary adder. It accepts two operands and a carry-in, and returns a 16-bit sum and a carry-out. The adder is built from four 4-bit groups. Each group forms per-bit generate (AND) and propagate (inclusive OR) terms. Each group expands every internal carry as a flat sum of products over its own terms and its carry-in. Each group also exports a group generate and a group propagate.

A second lookahead level combines the group terms into the carries entering groups 1 to 3 and into the final carry-out. Each of these carries is a flat expression of the group terms and the adder's carry-in, so no carry waits on a lower group's carry. A build-time mode parameter instead chains each group's own carry-out into the next group. That variant is slower but smaller, and it produces identical results.

The block holds no state. It is meant to sit between registers in a datapath, where its settling time is what counts.

Top module: `hcla_adder16`

## Requirements
- R1: In lookahead mode, {cout_o, sum_o} equals x_i + y_i + cin_i, taken as a 17-bit unsigned sum, for every operand combination.
- R2: In ripple-of-groups mode (MODE = CARRY_RIPPLE), {cout_o, sum_o} equals the same 17-bit sum as in R1.
- R3: A carry-in can travel the whole word. With x_i = 16'hFFFF, y_i = 16'h0000 and cin_i = 1, the result is sum_o = 16'h0000 and cout_o = 1. With both operands 16'hFFFF and cin_i = 1, the result is sum_o = 16'hFFFF and cout_o = 1.
- R4: The carry entering group k (bit position 4k) equals the carry out of the arithmetic sum of the lower 4k bits plus cin_i. When bit 4k-1 is set in both operands and all other bits are clear, sum_o has only bit 4k set.
- R5: A group's generate is 1 exactly when its two 4-bit slices overflow with a carry-in of 0. Its generate OR propagate is 1 exactly when they overflow with a carry-in of 1.
- R6: Zero operands give sum_o = 16'h0000 and cout_o = 0 when cin_i = 0, and sum_o = 16'h0001 and cout_o = 0 when cin_i = 1.
- R7: Adding 4'b0001 to 4'b1011 in the low group, with all other bits and cin_i at 0, gives sum_o = 16'h000C and cout_o = 0.
- R8: The outputs follow the inputs without any clock. A change of the inputs between clock edges shows up at the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Random operands rarely produce a carry that is generated in the low group and then propagated through every higher group. That is the case in which the second lookahead level must deliver a carry that comes only from its group terms. The directed vectors therefore generate a carry at one group boundary and make every bit above it propagate, for example 16'hFFF8 + 16'h0008. They also place a single generate at each group boundary in turn. Both build modes are instantiated side by side and receive identical stimulus, so each vector also compares the lookahead and ripple structures.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_GROUP_W    = 4;
  localparam int DEF_NUM_GROUPS = 4;

  typedef enum logic {
    CARRY_LOOKAHEAD = 1'b0,
    CARRY_RIPPLE    = 1'b1
  } carry_mode_e;
endpackage

// File: rtl/cla_bitpg.sv
module cla_bitpg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o
);
  // Each carry is a flat OR of product terms; no carry feeds another.
  always_comb begin
    logic acc;
    logic term;
    for (int j = 1; j <= N; j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gen_i[k];
        for (int m = k + 1; m < j; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      term = cin_i;
      for (int m = 0; m < j; m++) term = term & prop_i[m];
      carry_o[j] = acc | term;
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a_i,
  input  logic [GROUP_W-1:0] b_i,
  input  logic               cin_i,
  output logic [GROUP_W-1:0] sum_o,
  output logic               gen_o,
  output logic               prop_o,
  output logic               cout_o
);
  logic [GROUP_W-1:0] g;
  logic [GROUP_W-1:0] p;
  logic [GROUP_W:0]   cc;

  cla_bitpg #(.W(GROUP_W)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (g),
    .prop_o (p)
  );

  cla_lookahead #(.N(GROUP_W)) u_la (
    .gen_i   (g),
    .prop_i  (p),
    .cin_i   (cin_i),
    .carry_o (cc[GROUP_W:1])
  );

  assign cc[0]  = cin_i;
  assign sum_o  = a_i ^ b_i ^ cc[GROUP_W-1:0];
  assign cout_o = cc[GROUP_W];

  // Group terms: a carry born inside the group and surviving to its top,
  // and a carry-in passed by every bit.
  always_comb begin
    logic term;
    gen_o = 1'b0;
    for (int k = 0; k < GROUP_W; k++) begin
      term = g[k];
      for (int m = k + 1; m < GROUP_W; m++) term = term & p[m];
      gen_o = gen_o | term;
    end
    prop_o = &p;
  end
endmodule

// File: rtl/hcla_adder16.sv
module hcla_adder16
  import cla_pkg::*;
#(
  parameter int          GROUP_W    = DEF_GROUP_W,
  parameter int          NUM_GROUPS = DEF_NUM_GROUPS,
  parameter carry_mode_e MODE       = CARRY_LOOKAHEAD,
  localparam int         DATA_W     = GROUP_W * NUM_GROUPS
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS-1:0] grp_co;
  logic [NUM_GROUPS:0]   grp_c;

  assign grp_c[0] = cin_i;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    cla_group #(.GROUP_W(GROUP_W)) u_grp (
      .a_i    (x_i[k*GROUP_W +: GROUP_W]),
      .b_i    (y_i[k*GROUP_W +: GROUP_W]),
      .cin_i  (grp_c[k]),
      .sum_o  (sum_o[k*GROUP_W +: GROUP_W]),
      .gen_o  (grp_g[k]),
      .prop_o (grp_p[k]),
      .cout_o (grp_co[k])
    );
  end

  if (MODE == CARRY_LOOKAHEAD) begin : g_level2
    cla_lookahead #(.N(NUM_GROUPS)) u_l2 (
      .gen_i   (grp_g),
      .prop_i  (grp_p),
      .cin_i   (cin_i),
      .carry_o (grp_c[NUM_GROUPS:1])
    );
  end else begin : g_ripple
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_chain
      assign grp_c[k+1] = grp_co[k];
    end
  end

  assign cout_o = grp_c[NUM_GROUPS];
endmodule

// File: rtl/hcla_adder16_chk.sv
module hcla_adder16_chk #(
  parameter int  GROUP_W    = 4,
  parameter int  NUM_GROUPS = 4,
  localparam int DATA_W     = GROUP_W * NUM_GROUPS
) (
  input logic [DATA_W-1:0]     x_i,
  input logic [DATA_W-1:0]     y_i,
  input logic                  cin_i,
  input logic [DATA_W-1:0]     sum_o,
  input logic                  cout_o,
  input logic [NUM_GROUPS-1:0] grp_g,
  input logic [NUM_GROUPS-1:0] grp_p,
  input logic [NUM_GROUPS-1:0] grp_co,
  input logic [NUM_GROUPS-1:0] grp_c
);
  function automatic logic carry_at(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b,
                                    input logic ci, input int n);
    logic [DATA_W:0] mask;
    logic [DATA_W:0] t;
    mask = ({{DATA_W{1'b0}}, 1'b1} << n) - 1'b1;
    t = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{DATA_W{1'b0}}, ci};
    return t[n];
  endfunction

  function automatic logic slice_ovf(input logic [GROUP_W-1:0] a,
                                     input logic [GROUP_W-1:0] b,
                                     input logic ci);
    logic [GROUP_W:0] t;
    t = {1'b0, a} + {1'b0, b} + {{GROUP_W{1'b0}}, ci};
    return t[GROUP_W];
  endfunction

  always_comb begin
    AST_SUM_MATCH: assert ({cout_o, sum_o} ==
                           {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i}); // R1
    for (int k = 0; k < NUM_GROUPS; k++) begin
      AST_GRP_CIN: assert (grp_c[k] == carry_at(x_i, y_i, cin_i, k*GROUP_W)); // R4
      AST_GRP_COUT: assert (grp_co[k] == carry_at(x_i, y_i, cin_i, (k+1)*GROUP_W)); // R4
      AST_GRP_GEN: assert (grp_g[k] == slice_ovf(x_i[k*GROUP_W +: GROUP_W],
                                                 y_i[k*GROUP_W +: GROUP_W], 1'b0)); // R5
      AST_GRP_PROP: assert ((grp_g[k] | grp_p[k]) ==
                            slice_ovf(x_i[k*GROUP_W +: GROUP_W],
                                      y_i[k*GROUP_W +: GROUP_W], 1'b1)); // R5
    end
  end
endmodule

bind hcla_adder16 hcla_adder16_chk #(
  .GROUP_W    (GROUP_W),
  .NUM_GROUPS (NUM_GROUPS)
) chk_i (
  .x_i    (x_i),
  .y_i    (y_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .grp_g  (grp_g),
  .grp_p  (grp_p),
  .grp_co (grp_co),
  .grp_c  (grp_c[NUM_GROUPS-1:0])
);

// File: tb/hcla_adder16_tb_top.sv
`timescale 1ns/1ps
module hcla_adder16_tb_top;
  import cla_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x = '0;
  logic [15:0] y = '0;
  logic        cin = 1'b0;
  logic [15:0] sum_la, sum_rp;
  logic        cout_la, cout_rp;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hcla_adder16 #(.MODE(CARRY_LOOKAHEAD)) dut_i (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(sum_la), .cout_o(cout_la));

  hcla_adder16 #(.MODE(CARRY_RIPPLE)) dut_rip_i (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(sum_rp), .cout_o(cout_rp));

  function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive after a rising edge, compare on the following falling edge.
  task automatic run(input string tag, input logic [15:0] a, input logic [15:0] b,
                     input logic c, input logic [16:0] exp);
    @(posedge clk);
    x = a; y = b; cin = c;
    @(negedge clk);
    chk({tag, " R1 lookahead"}, {cout_la, sum_la}, exp);
    chk({tag, " R2 ripple"},    {cout_rp, sum_rp}, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R6: zero operands, both carry-in values
    run("R6 zero c0", 16'h0000, 16'h0000, 1'b0, 17'h00000);
    run("R6 zero c1", 16'h0000, 16'h0000, 1'b1, 17'h00001);

    // R3: carry-in across the full word
    run("R3 ffff+0+1",    16'hFFFF, 16'h0000, 1'b1, 17'h10000);
    run("R3 ffff+ffff+1", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);

    // R7: low-group example
    run("R7 0001+1011", 16'h0001, 16'h000B, 1'b0, 17'h0000C);

    // R4: a single generate at each group boundary
    for (int k = 1; k < 4; k++) begin
      run("R4 boundary", 16'h1 << (4*k-1), 16'h1 << (4*k-1), 1'b0, 17'h1 << (4*k));
    end

    // R5: generate in group 0, propagate through groups 1 to 3
    run("R5 gen+prop", 16'hFFF8, 16'h0008, 1'b0, 17'h10000);
    // R5: propagate-only group with no carry-in passes nothing
    run("R5 prop only", 16'h00F0, 16'h000F, 1'b0, 17'h000FF);
    run("R5 prop c1",   16'hF0F0, 16'h0F0F, 1'b1, 17'h10000);

    // Alternating patterns (R1, R2)
    run("alt 5555+aaaa+1", 16'h5555, 16'hAAAA, 1'b1, 17'h10000);
    run("alt 5555+5555",   16'h5555, 16'h5555, 1'b0, 17'h0AAAA);
    run("alt aaaa+aaaa",   16'hAAAA, 16'hAAAA, 1'b0, 17'h15554);

    // R8: inputs change between edges, outputs settle before the next edge
    @(negedge clk);
    #1 x = 16'h1234; y = 16'h4321; cin = 1'b1;
    #2;
    chk("R8 no-clock lookahead", {cout_la, sum_la}, 17'h05556);
    chk("R8 no-clock ripple",    {cout_rp, sum_rp}, 17'h05556);

    // Random vectors (R1, R2)
    void'($urandom(32'h5EED_0A11));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a, b;
      logic        c;
      a = 16'($urandom);
      b = 16'($urandom);
      c = 1'($urandom);
      run("rand", a, b, c, ref_add(a, b, c));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule